// File: doc/BRIEF.md
# Command Decoder and Tone Generator

This block sits behind a serial command front end of a segment display controller. Each time the front end has assembled a 9-bit command word, it presents the word together with a one-cycle valid strobe. The block decodes the word against a set of patterns that contain don't-care bits, and it keeps the configuration state of the controller. That state is: oscillator/bias on, display on, clock source, time-base enable, watchdog enable, interrupt enable and a 3-bit rate code. Two commands produce single-cycle clear pulses for the time base and the watchdog.

The block also drives a complementary buzzer pair. The pair runs at one of two tone rates, and both tone rates are derived from a tick input that pulses once per period of the 32.768 kHz reference. The fast tone changes phase every 4 ticks, which gives about 4 kHz. The slow tone changes phase every 8 ticks, which gives about 2 kHz. While the tone is off, both buzzer lines are held low.

In the requirements, a command word is written most significant bit first. Bit 0 is always a don't-care, and `x` marks any other don't-care bit. All configuration changes appear at the outputs in the clock cycle after the strobed word.

Top module: `cmd_tone_ctrl`

## Requirements
- R1: After synchronous reset, every output is low: system off, display off, internal RC source selected, time base, watchdog and interrupt disabled, rate code 000, both buzzer lines low, and no clear pulse.
- R2: With `cmd_valid` high, 0000_0000_x clears `sys_on` and 0000_0001_x sets it, while 0000_0010_x clears `lcd_on` and 0000_0011_x sets it.
- R3: The following words control the two timer enables: 0000_0100_x clears `tbase_en`, 0000_0110_x sets `tbase_en`, 0000_0101_x clears `wdog_en` and 0000_0111_x sets `wdog_en`.
- R4: 0000_1101_x raises `tbase_clr` and 0000_1111_x raises `wdog_clr`, each for exactly the one cycle after the strobe.
- R5: 0001_10xx_x clears `ext_clk_sel`, which selects the internal RC source, and 0001_11xx_x sets it.
- R6: While `ext_clk_sel` is high, 0000_0000_x leaves `sys_on` unchanged.
- R7: 100x_0xxx_x clears `irq_en` and 100x_1xxx_x sets it.
- R8: 101x_0fff_x loads `rate_sel` with fff, taken from word bits 3..1. A word of the form 101x_1xxx_x changes nothing.
- R9: 010x_xxxx_x selects the fast tone, 0110_xxxx_x selects the slow tone and 0000_1000_x turns the tone off. While the tone is off, `tone_p` and `tone_n` are both low.
- R10: While a tone is on, `tone_n` is the complement of `tone_p`. A tone command, including a repeat of the current one, restarts the tone with `tone_p` low. After that, `tone_p` toggles on every 4th `tick` for the fast tone and on every 8th `tick` for the slow tone.
- R11: Some words change no output: words strobed without `cmd_valid`, the two test words 1110_0000_x and 1110_0011_x, and any word that matches no listed pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 9 | Command word |
| tick | input | 1 | One pulse per 32.768 kHz period |
| sys_on | output | 1 | Oscillator and bias enabled |
| lcd_on | output | 1 | Display enabled |
| ext_clk_sel | output | 1 | External clock source selected |
| tbase_en | output | 1 | Time-base output enabled |
| wdog_en | output | 1 | Watchdog flag enabled |
| irq_en | output | 1 | Interrupt output enabled |
| rate_sel | output | 3 | Time-base rate code |
| tbase_clr | output | 1 | One-cycle time-base clear |
| wdog_clr | output | 1 | One-cycle watchdog clear |
| tone_p | output | 1 | Buzzer line, true phase |
| tone_n | output | 1 | Buzzer line, complementary phase |

## Verification
The directed part covers the following:
- every listed code, with its don't-care bits set both high and low;
- the disable-the-system word while the external source is selected, which is the only command whose effect depends on other state;
- the rate pattern with bit 4 set, which separates a correct don't-care mask from one that is too wide;
- the test words, which the decoder must accept but must not act on.

Tone phase is counted tick by tick for both rates, and again after a re-issued tone command, to show that the command restarts the count.

Random words with half of them forced into the 0000 prefix group are mixed with random ticks and random strobes. This exposes overlaps between patterns, and actions taken on words without the strobe, which a single directed sequence would miss.

// File: rtl/cmdtone_pkg.sv
package cmdtone_pkg;

    localparam int CMD_W  = 9;
    localparam int RATE_W = 3;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_SYS_OFF,
        OP_SYS_ON,
        OP_LCD_OFF,
        OP_LCD_ON,
        OP_TB_OFF,
        OP_WD_OFF,
        OP_TB_ON,
        OP_WD_ON,
        OP_TONE_OFF,
        OP_CLR_TB,
        OP_CLR_WD,
        OP_SRC_RC,
        OP_SRC_EXT,
        OP_TONE_FAST,
        OP_TONE_SLOW,
        OP_IRQ_OFF,
        OP_IRQ_ON,
        OP_RATE,
        OP_TEST
    } op_e;

    typedef enum logic [1:0] {
        TONE_IDLE,
        TONE_FAST,
        TONE_SLOW
    } tone_e;

    typedef struct packed {
        op_e               op;
        logic [RATE_W-1:0] rate;
    } dec_t;

    typedef struct packed {
        logic              sys_on;
        logic              lcd_on;
        logic              ext_src;
        logic              tb_en;
        logic              wd_en;
        logic              irq_en;
        logic [RATE_W-1:0] rate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '0;

    // Pattern match on bits 8..1; bit 0 is never examined.
    function automatic dec_t decode_word(input logic [CMD_W-1:0] w);
        dec_t d;
        d.op   = OP_NONE;
        d.rate = w[RATE_W:1];
        casez (w[8:1])
            8'b0000_0000: d.op = OP_SYS_OFF;
            8'b0000_0001: d.op = OP_SYS_ON;
            8'b0000_0010: d.op = OP_LCD_OFF;
            8'b0000_0011: d.op = OP_LCD_ON;
            8'b0000_0100: d.op = OP_TB_OFF;
            8'b0000_0101: d.op = OP_WD_OFF;
            8'b0000_0110: d.op = OP_TB_ON;
            8'b0000_0111: d.op = OP_WD_ON;
            8'b0000_1000: d.op = OP_TONE_OFF;
            8'b0000_1101: d.op = OP_CLR_TB;
            8'b0000_1111: d.op = OP_CLR_WD;
            8'b0001_10??: d.op = OP_SRC_RC;
            8'b0001_11??: d.op = OP_SRC_EXT;
            8'b010?_????: d.op = OP_TONE_FAST;
            8'b0110_????: d.op = OP_TONE_SLOW;
            8'b100?_0???: d.op = OP_IRQ_OFF;
            8'b100?_1???: d.op = OP_IRQ_ON;
            8'b101?_0???: d.op = OP_RATE;
            8'b1110_0000: d.op = OP_TEST;
            8'b1110_0011: d.op = OP_TEST;
            default:      d.op = OP_NONE;
        endcase
        return d;
    endfunction

    function automatic logic is_tone_op(input op_e op);
        return (op == OP_TONE_OFF) || (op == OP_TONE_FAST) || (op == OP_TONE_SLOW);
    endfunction

endpackage

// File: rtl/cmdtone_decode.sv
module cmdtone_decode
    import cmdtone_pkg::*;
(
    input  logic             valid,
    input  logic [CMD_W-1:0] word,
    output dec_t             dec
);

    dec_t raw;

    always_comb begin
        raw = decode_word(word);
        dec = raw;
        if (!valid) begin
            dec.op = OP_NONE;
        end
    end

endmodule

// File: rtl/cmdtone_cfg.sv
module cmdtone_cfg
    import cmdtone_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dec_t dec,
    output cfg_t cfg,
    output logic clr_tb,
    output logic clr_wd
);

    cfg_t cfg_q;
    cfg_t cfg_d;
    logic clr_tb_q;
    logic clr_wd_q;

    always_comb begin
        cfg_d = cfg_q;
        unique case (dec.op)
            OP_SYS_OFF: if (!cfg_q.ext_src) cfg_d.sys_on = 1'b0;
            OP_SYS_ON:  cfg_d.sys_on  = 1'b1;
            OP_LCD_OFF: cfg_d.lcd_on  = 1'b0;
            OP_LCD_ON:  cfg_d.lcd_on  = 1'b1;
            OP_TB_OFF:  cfg_d.tb_en   = 1'b0;
            OP_TB_ON:   cfg_d.tb_en   = 1'b1;
            OP_WD_OFF:  cfg_d.wd_en   = 1'b0;
            OP_WD_ON:   cfg_d.wd_en   = 1'b1;
            OP_SRC_RC:  cfg_d.ext_src = 1'b0;
            OP_SRC_EXT: cfg_d.ext_src = 1'b1;
            OP_IRQ_OFF: cfg_d.irq_en  = 1'b0;
            OP_IRQ_ON:  cfg_d.irq_en  = 1'b1;
            OP_RATE:    cfg_d.rate    = dec.rate;
            default:    cfg_d = cfg_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RESET;
            clr_tb_q <= 1'b0;
            clr_wd_q <= 1'b0;
        end else begin
            cfg_q    <= cfg_d;
            clr_tb_q <= (dec.op == OP_CLR_TB);
            clr_wd_q <= (dec.op == OP_CLR_WD);
        end
    end

    assign cfg    = cfg_q;
    assign clr_tb = clr_tb_q;
    assign clr_wd = clr_wd_q;

    // R6
    sysoff_ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_SYS_OFF && cfg_q.ext_src) |=> $stable(cfg_q.sys_on));

    // R4
    tb_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_tb_q) |-> $past(dec.op == OP_CLR_TB));

    // R4
    wd_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wd_q |-> $past(dec.op == OP_CLR_WD));

    // R11
    idle_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_NONE || dec.op == OP_TEST) |=> $stable(cfg_q));

    // R8
    rate_only_by_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.op != OP_RATE) |=> $stable(cfg_q.rate));

endmodule

// File: rtl/cmdtone_tone.sv
module cmdtone_tone
    import cmdtone_pkg::*;
#(
    parameter int FAST_HALF = 4,
    parameter int SLOW_HALF = 8
) (
    input  logic clk,
    input  logic rst,
    input  dec_t dec,
    input  logic tick,
    output logic tone_p,
    output logic tone_n
);

    localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_HALF - 1);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_HALF - 1);

    tone_e            mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ph_q;
    logic [CNT_W-1:0] limit;
    logic             set;

    assign set   = is_tone_op(dec.op);
    assign limit = (mode_q == TONE_FAST) ? FAST_LIM : SLOW_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TONE_IDLE;
            cnt_q  <= '0;
            ph_q   <= 1'b0;
        end else if (set) begin
            unique case (dec.op)
                OP_TONE_FAST: mode_q <= TONE_FAST;
                OP_TONE_SLOW: mode_q <= TONE_SLOW;
                default:      mode_q <= TONE_IDLE;
            endcase
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else if (mode_q != TONE_IDLE && tick) begin
            if (cnt_q == limit) begin
                cnt_q <= '0;
                ph_q  <= ~ph_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tone_p = (mode_q != TONE_IDLE) &&  ph_q;
    assign tone_n = (mode_q != TONE_IDLE) && !ph_q;

    // R10
    tone_no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set && !tick) |=> $stable({tone_p, tone_n}));

    // R9
    tone_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_TONE_OFF) |=> (!tone_p && !tone_n));

    // R10
    tone_restart_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.op == OP_TONE_FAST || dec.op == OP_TONE_SLOW) |=> (!tone_p && tone_n));

endmodule

// File: rtl/cmd_tone_ctrl.sv
module cmd_tone_ctrl
    import cmdtone_pkg::*;
#(
    parameter int FAST_HALF = 4,
    parameter int SLOW_HALF = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              tick,
    output logic              sys_on,
    output logic              lcd_on,
    output logic              ext_clk_sel,
    output logic              tbase_en,
    output logic              wdog_en,
    output logic              irq_en,
    output logic [RATE_W-1:0] rate_sel,
    output logic              tbase_clr,
    output logic              wdog_clr,
    output logic              tone_p,
    output logic              tone_n
);

    dec_t dec;
    cfg_t cfg;

    cmdtone_decode u_dec (
        .valid (cmd_valid),
        .word  (cmd_word),
        .dec   (dec)
    );

    cmdtone_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .cfg    (cfg),
        .clr_tb (tbase_clr),
        .clr_wd (wdog_clr)
    );

    cmdtone_tone #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_tone (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .tick   (tick),
        .tone_p (tone_p),
        .tone_n (tone_n)
    );

    assign sys_on      = cfg.sys_on;
    assign lcd_on      = cfg.lcd_on;
    assign ext_clk_sel = cfg.ext_src;
    assign tbase_en    = cfg.tb_en;
    assign wdog_en     = cfg.wd_en;
    assign irq_en      = cfg.irq_en;
    assign rate_sel    = cfg.rate;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sys_on && !tbase_clr && !wdog_clr && !tone_p && !tone_n));

endmodule

// File: tb/cmd_tone_ctrl_test.sv
module cmd_tone_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [8:0] cmd_word = '0;
    logic       tick = 1'b0;
    logic       sys_on, lcd_on, ext_clk_sel, tbase_en, wdog_en, irq_en;
    logic [2:0] rate_sel;
    logic       tbase_clr, wdog_clr, tone_p, tone_n;

    int total = 0;
    int bad = 0;

    // expected state
    logic e_sys, e_lcd, e_ext, e_tb, e_wd, e_irq, e_ctb, e_cwd, e_ph;
    logic [2:0] e_rate;
    int e_mode, e_cnt;

    always #4 clk = ~clk;

    cmd_tone_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .tick(tick),
        .sys_on(sys_on), .lcd_on(lcd_on), .ext_clk_sel(ext_clk_sel), .tbase_en(tbase_en),
        .wdog_en(wdog_en), .irq_en(irq_en), .rate_sel(rate_sel), .tbase_clr(tbase_clr),
        .wdog_clr(wdog_clr), .tone_p(tone_p), .tone_n(tone_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        e_sys = 0; e_lcd = 0; e_ext = 0; e_tb = 0; e_wd = 0; e_irq = 0;
        e_ctb = 0; e_cwd = 0; e_ph = 0; e_rate = 0; e_mode = 0; e_cnt = 0;
    endtask

    task automatic model_step(input logic v, input logic [8:0] w, input logic t);
        logic tone_cmd;
        tone_cmd = 0;
        e_ctb = 0;
        e_cwd = 0;
        if (v) begin
            if (w[8:5] == 4'b0000) begin
                case (w[4:1])
                    4'd0:  if (!e_ext) e_sys = 0;
                    4'd1:  e_sys = 1;
                    4'd2:  e_lcd = 0;
                    4'd3:  e_lcd = 1;
                    4'd4:  e_tb = 0;
                    4'd5:  e_wd = 0;
                    4'd6:  e_tb = 1;
                    4'd7:  e_wd = 1;
                    4'd8:  begin tone_cmd = 1; e_mode = 0; end
                    4'd13: e_ctb = 1;
                    4'd15: e_cwd = 1;
                    default: ;
                endcase
            end else if (w[8:5] == 4'b0001 && w[4]) begin
                e_ext = w[3];
            end else if (w[8:6] == 3'b010) begin
                tone_cmd = 1; e_mode = 1;
            end else if (w[8:5] == 4'b0110) begin
                tone_cmd = 1; e_mode = 2;
            end else if (w[8:6] == 3'b100) begin
                e_irq = w[4];
            end else if (w[8:6] == 3'b101 && !w[4]) begin
                e_rate = w[3:1];
            end
        end
        if (tone_cmd) begin
            e_cnt = 0; e_ph = 0;
        end else if (e_mode != 0 && t) begin
            if (e_cnt == ((e_mode == 1) ? 3 : 7)) begin
                e_cnt = 0; e_ph = ~e_ph;
            end else begin
                e_cnt++;
            end
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({"R2 sys_on ", ctx}, sys_on, e_sys);
        chk({"R2 lcd_on ", ctx}, lcd_on, e_lcd);
        chk({"R5 ext_clk_sel ", ctx}, ext_clk_sel, e_ext);
        chk({"R3 tbase_en ", ctx}, tbase_en, e_tb);
        chk({"R3 wdog_en ", ctx}, wdog_en, e_wd);
        chk({"R7 irq_en ", ctx}, irq_en, e_irq);
        chk({"R8 rate_sel ", ctx}, rate_sel, e_rate);
        chk({"R4 tbase_clr ", ctx}, tbase_clr, e_ctb);
        chk({"R4 wdog_clr ", ctx}, wdog_clr, e_cwd);
        chk({"R10 tone_p ", ctx}, tone_p, (e_mode != 0) && e_ph);
        chk({"R10 tone_n ", ctx}, tone_n, (e_mode != 0) && !e_ph);
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic v, input logic [8:0] w, input logic t, input string ctx);
        cmd_valid = v; cmd_word = w; tick = t;
        @(posedge clk);
        model_step(v, w, t);
        @(negedge clk);
        cmd_valid = 0; tick = 0;
        compare_all(ctx);
    endtask

    task automatic cmd(input logic [8:0] w, input string ctx);
        step(1'b1, w, 1'b0, ctx);
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        compare_all("R1 reset");
        chk("R1 tone_p reset", tone_p, 0);

        // R2 / R3 / R4 directed, bit 0 set to 1
        cmd(9'b0000_0001_1, "R2 sys on");
        chk("R2 sys literal", sys_on, 1);
        cmd(9'b0000_0011_0, "R2 lcd on");
        cmd(9'b0000_0110_1, "R3 tb on");
        cmd(9'b0000_0111_1, "R3 wd on");
        chk("R3 wd literal", wdog_en, 1);
        cmd(9'b0000_1101_1, "R4 clr tb");
        chk("R4 tb pulse", tbase_clr, 1);
        step(1'b0, 9'h0, 1'b0, "R4 tb pulse end");
        chk("R4 tb pulse end literal", tbase_clr, 0);
        cmd(9'b0000_1111_0, "R4 clr wd");
        chk("R4 wd pulse", wdog_clr, 1);
        cmd(9'b0000_0101_0, "R3 wd off");

        // R6: system off ignored with external source
        cmd(9'b0001_1110_1, "R5 ext");
        cmd(9'b0000_0000_1, "R6 sysoff ext");
        chk("R6 sys stays on", sys_on, 1);
        cmd(9'b0001_1001_0, "R5 rc");
        cmd(9'b0000_0000_0, "R2 sysoff rc");
        chk("R2 sys off literal", sys_on, 0);

        // R7 / R8
        cmd(9'b1001_1010_1, "R7 irq on");
        chk("R7 irq literal", irq_en, 1);
        cmd(9'b1011_0101_0, "R8 rate 101");
        chk("R8 rate literal", rate_sel, 5);
        cmd(9'b1010_1011_1, "R8 bit4 ignored");
        chk("R8 rate kept", rate_sel, 5);

        // R11: test words, unlisted words, no strobe
        cmd(9'b1110_0000_1, "R11 test word a");
        cmd(9'b1110_0011_0, "R11 test word b");
        cmd(9'b0000_1001_0, "R11 unlisted");
        cmd(9'b0111_0000_0, "R11 unlisted 0111");
        step(1'b0, 9'b0000_0001_0, 1'b1, "R11 no strobe");
        chk("R11 rate after ignored", rate_sel, 5);

        // R9 / R10 fast tone
        cmd(9'b0101_0110_1, "R9 fast");
        chk("R10 fast start n", tone_n, 1);
        for (int i = 1; i <= 12; i++) step(1'b0, 9'h0, 1'b1, "R10 fast tick");
        chk("R10 fast after 12 ticks", tone_p, 1);
        // restart by repeat
        cmd(9'b0100_0000_0, "R10 restart");
        chk("R10 restart p low", tone_p, 0);
        for (int i = 1; i <= 3; i++) step(1'b0, 9'h0, 1'b1, "R10 fast 3");
        chk("R10 no toggle at 3", tone_p, 0);
        step(1'b0, 9'h0, 1'b1, "R10 fast 4");
        chk("R10 toggle at 4", tone_p, 1);
        // slow tone
        cmd(9'b0110_1111_1, "R9 slow");
        for (int i = 1; i <= 7; i++) step(1'b0, 9'h0, 1'b1, "R10 slow 7");
        chk("R10 slow no toggle at 7", tone_p, 0);
        step(1'b0, 9'h0, 1'b1, "R10 slow 8");
        chk("R10 slow toggle at 8", tone_p, 1);
        cmd(9'b0000_1000_1, "R9 off");
        chk("R9 off p", tone_p, 0);
        chk("R9 off n", tone_n, 0);
        step(1'b0, 9'h0, 1'b1, "R9 off tick");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [8:0] w;
            logic v, t;
            w = 9'($urandom);
            if ($urandom % 2 == 0) w[8:5] = 4'b0000;
            v = ($urandom % 4) != 0;
            t = ($urandom % 3) == 0;
            step(v, w, t, "random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule